// File: doc/BRIEF.md
# Armable Capture/Compare Timer Channel

One channel of a system timer. It holds a stored 32-bit value and an arm state (idle, armed for compare, armed for capture), and it watches one of two views of a shared timebase: a fine view and a coarse view. When armed for compare, it fires once the selected view equals the stored value. When armed for capture, it copies the selected view into the stored value on a chosen edge of an asynchronous input. After a capture it either stays armed or drops back to idle.

Software drives the channel through write strobes: a configuration word, the value register, a save/restore alias of the value register, and separate arm-set and arm-clear strobes. Each strobe follows a fixed priority. The channel reports a one-cycle event pulse, an output level that toggles on every compare match, and its arm status. The timebase counter and interrupt aggregation live outside this block.

Top module: `cc_channel`

## Requirements
- R1: After reset, armed_o, event_o and out_o are 0 and val_o is 0.
- R2: A write to the value register (val_we_i) stores val_wdata_i and arms compare. While compare-armed, the selected view equals val_o in some cycle. Then event_o is 1 for exactly the next cycle, out_o toggles and the channel returns to idle.
- R3: Configuration bit 4 selects the view. 0 selects tb_fine_i and 1 selects tb_coarse_i. It applies to both compare and capture, and the unselected view is ignored.
- R4: A configuration write (cfg_we_i) arms capture when bit 0 of cfg_wdata_i is 1, and it forces idle when bit 0 is 0.
- R5: Configuration bits 2:1 select the capture edge: 00 none, 01 falling, 10 rising, 11 rising. edge_i passes through a two-stage synchroniser and an edge detector. A transition of edge_i set up before clock edge k raises event_o after edge k+2 and latches the selected view sampled at that edge into val_o.
- R6: When configuration bit 3 (rearm) is 1, a capture leaves the channel capture-armed. When it is 0, the capture returns the channel to idle. A compare match always disarms, whatever the rearm bit.
- R7: arm_set_i leaves a channel unchanged if it is still capture-armed after any event in that cycle. Otherwise it arms compare using the existing stored value.
- R8: arm_clr_i returns the channel to idle and raises no event by itself. A compare or capture event in the same cycle is still reported on event_o.
- R9: A write through the alias (val_alias_we_i) updates val_o only. It changes neither the arm state nor the configuration.
- R10: Strobes in one cycle take effect in this order: arm_clr_i first, then cfg_we_i, then val_we_i, then arm_set_i. A value or alias write in the same cycle as a capture wins over the captured value.
- R11: armed_o is 0 when idle and 1 when armed for compare or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration word: [4] view, [3] rearm, [2:1] edge, [0] capture mode |
| val_we_i | input | 1 | Value register write strobe (arms compare) |
| val_alias_we_i | input | 1 | Save/restore alias write strobe |
| val_wdata_i | input | W | Write data for the value register and the alias |
| arm_set_i | input | 1 | Arm-set strobe |
| arm_clr_i | input | 1 | Arm-clear strobe |
| edge_i | input | 1 | Asynchronous capture input |
| tb_fine_i | input | W | Fine timebase view |
| tb_coarse_i | input | W | Coarse timebase view |
| val_o | output | W | Stored capture/compare value |
| event_o | output | 1 | One-cycle event pulse |
| out_o | output | 1 | Output level, toggled on compare match |
| armed_o | output | 1 | Arm status |

## Verification
The bench targets several corner cases and the failure each one would expose:
- **Capture timing.** The bench checks the exact cycle in which a capture fires after an input transition. A design with a missing or extra synchroniser stage fires one cycle off.
- **Arm-set on a capture-armed channel.** The timebase is held equal to the old stored value while the capture input is quiet. A design that wrongly switches to compare fires early.
- **Same-cycle conflicts.** The bench applies arm-clear together with a match, arm-clear together with a value write, and an alias write together with a capture. These expose a lost event, a wrong winner or a captured value that overwrites software.
- **Mode corners.** The bench drives an ignored edge, the none edge code, the unselected view and a rearm bit under compare. A design that decodes any of these wrongly produces spurious or missing events.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_CFG_W = 5;

  localparam logic [1:0] ESEL_NONE = 2'b00;
  localparam logic [1:0] ESEL_FALL = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_CAP  = 2'd2
  } arm_state_e;

  typedef struct packed {
    logic       coarse;
    logic       rearm;
    logic [1:0] esel;
    logic       cap_mode;
  } cc_cfg_t;
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[PIPE_W-2:0], sig_i};
  end

  // last sync stage vs. its history bit
  assign rise_o =  pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall_o = ~pipe_q[SYNC_STAGES-1] &  pipe_q[SYNC_STAGES];
endmodule

// File: rtl/cc_cmp.sv
module cc_cmp #(
  parameter int W = 32
) (
  input  logic         coarse_i,
  input  logic [W-1:0] tb_fine_i,
  input  logic [W-1:0] tb_coarse_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] view_o,
  output logic         hit_o
);
  assign view_o = coarse_i ? tb_coarse_i : tb_fine_i;
  assign hit_o  = (view_o == val_i);
endmodule

// File: rtl/cc_arm_ctl.sv
module cc_arm_ctl
  import cc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_hit_i,
  input  logic       cap_edge_i,
  input  logic       rearm_i,
  input  logic       cfg_we_i,
  input  logic       cfg_cap_i,
  input  logic       val_we_i,
  input  logic       arm_set_i,
  input  logic       arm_clr_i,
  output arm_state_e state_o,
  output logic       cmp_fire_o,
  output logic       cap_fire_o
);
  arm_state_e state_q, post_st, state_d;

  assign cmp_fire_o = (state_q == ST_CMP) && cmp_hit_i;
  assign cap_fire_o = (state_q == ST_CAP) && cap_edge_i;

  always_comb begin
    post_st = state_q;
    if (cmp_fire_o) post_st = ST_IDLE;
    if (cap_fire_o) post_st = rearm_i ? ST_CAP : ST_IDLE;

    state_d = post_st;
    if (arm_clr_i)      state_d = ST_IDLE;
    else if (cfg_we_i)  state_d = cfg_cap_i ? ST_CAP : ST_IDLE;
    else if (val_we_i)  state_d = ST_CMP;
    else if (arm_set_i) state_d = (post_st == ST_CAP) ? ST_CAP : ST_CMP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R8
  clr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_clr_i |=> (state_q == ST_IDLE));

  // R6
  rearm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_fire_o && rearm_i && !arm_clr_i && !cfg_we_i && !val_we_i)
    |=> (state_q == ST_CAP));

  // R7
  set_keeps_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAP && !cap_fire_o && arm_set_i && !arm_clr_i && !cfg_we_i && !val_we_i)
    |=> (state_q == ST_CAP));

  // R2
  cmp_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_fire_o && !arm_clr_i && !cfg_we_i && !val_we_i && !arm_set_i)
    |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CC_CFG_W-1:0] cfg_wdata_i,
  input  logic                val_we_i,
  input  logic                val_alias_we_i,
  input  logic [W-1:0]        val_wdata_i,
  input  logic                arm_set_i,
  input  logic                arm_clr_i,
  input  logic                edge_i,
  input  logic [W-1:0]        tb_fine_i,
  input  logic [W-1:0]        tb_coarse_i,
  output logic [W-1:0]        val_o,
  output logic                event_o,
  output logic                out_o,
  output logic                armed_o
);
  cc_cfg_t    cfg_w;
  logic       coarse_q, rearm_q;
  logic [1:0] esel_q;
  logic [W-1:0] val_q, view;
  logic       out_q, event_q;
  logic       hit, rise, fall, cap_edge, cmp_fire, cap_fire;
  arm_state_e state;

  assign cfg_w = cc_cfg_t'(cfg_wdata_i);

  cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (edge_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  cc_cmp #(.W(W)) u_cmp (
    .coarse_i   (coarse_q),
    .tb_fine_i  (tb_fine_i),
    .tb_coarse_i(tb_coarse_i),
    .val_i      (val_q),
    .view_o     (view),
    .hit_o      (hit)
  );

  always_comb begin
    case (esel_q)
      ESEL_NONE: cap_edge = 1'b0;
      ESEL_FALL: cap_edge = fall;
      default:   cap_edge = rise;
    endcase
  end

  cc_arm_ctl u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_hit_i (hit),
    .cap_edge_i(cap_edge),
    .rearm_i   (rearm_q),
    .cfg_we_i  (cfg_we_i),
    .cfg_cap_i (cfg_w.cap_mode),
    .val_we_i  (val_we_i),
    .arm_set_i (arm_set_i),
    .arm_clr_i (arm_clr_i),
    .state_o   (state),
    .cmp_fire_o(cmp_fire),
    .cap_fire_o(cap_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= 1'b0;
      rearm_q  <= 1'b0;
      esel_q   <= ESEL_NONE;
    end else if (cfg_we_i) begin
      coarse_q <= cfg_w.coarse;
      rearm_q  <= cfg_w.rearm;
      esel_q   <= cfg_w.esel;
    end
  end

  // software write beats a same-cycle capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         val_q <= '0;
    else if (val_we_i || val_alias_we_i) val_q <= val_wdata_i;
    else if (cap_fire)                   val_q <= view;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      event_q <= 1'b0;
    end else begin
      out_q   <= out_q ^ cmp_fire;
      event_q <= cmp_fire | cap_fire;
    end
  end

  assign val_o   = val_q;
  assign out_o   = out_q;
  assign event_o = event_q;
  assign armed_o = (state != ST_IDLE);

  // R11
  evt_from_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(armed_o));

  // R9
  alias_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_alias_we_i && !val_we_i && !cfg_we_i && !arm_set_i && !arm_clr_i && !cmp_fire && !cap_fire)
    |=> ($stable(armed_o) && val_o == $past(val_wdata_i)));

  // R2
  cmp_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_fire |=> (out_o != $past(out_o) && event_o));
endmodule

// File: tb/tb_cc_channel.sv
module tb_cc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 0, val_we = 0, alias_we = 0, arm_set = 0, arm_clr = 0, edge_in = 0;
  logic [4:0]   cfg_wdata = '0;
  logic [W-1:0] wdata = '0, tb_fine = '0, tb_coarse = '0;
  logic [W-1:0] val_o;
  logic         event_o, out_o, armed_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // bench model state: 0 idle, 1 compare, 2 capture
  int           m_st = 0;
  logic [W-1:0] m_val = '0;
  logic         m_out = 0, m_evt = 0, m_coarse = 0, m_rearm = 0;
  logic [1:0]   m_esel = 2'b00;
  logic [2:0]   m_sync = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .val_we_i(val_we), .val_alias_we_i(alias_we), .val_wdata_i(wdata),
    .arm_set_i(arm_set), .arm_clr_i(arm_clr), .edge_i(edge_in),
    .tb_fine_i(tb_fine), .tb_coarse_i(tb_coarse),
    .val_o(val_o), .event_o(event_o), .out_o(out_o), .armed_o(armed_o)
  );

  task automatic chk(input string t, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic clr_strobes();
    cfg_we = 0; val_we = 0; alias_we = 0; arm_set = 0; arm_clr = 0;
  endtask

  // one clock with model update and full output compare
  task automatic step();
    logic rise, fall, cap_e, cmpf, capf;
    logic [W-1:0] view;
    int post, nxt;
    rise  = m_sync[1] & ~m_sync[2];
    fall  = ~m_sync[1] & m_sync[2];
    cap_e = (m_esel == 2'b01) ? fall : (m_esel[1] ? rise : 1'b0);
    view  = m_coarse ? tb_coarse : tb_fine;
    cmpf  = (m_st == 1) && (view == m_val);
    capf  = (m_st == 2) && cap_e;
    post  = m_st;
    if (cmpf) post = 0;
    if (capf) post = m_rearm ? 2 : 0;
    nxt = post;
    if (arm_clr)      nxt = 0;
    else if (cfg_we)  nxt = cfg_wdata[0] ? 2 : 0;
    else if (val_we)  nxt = 1;
    else if (arm_set) nxt = (post == 2) ? 2 : 1;
    @(posedge clk);
    if (val_we || alias_we) m_val = wdata;
    else if (capf)          m_val = view;
    m_out = m_out ^ cmpf;
    m_evt = cmpf | capf;
    if (cfg_we) begin
      m_coarse = cfg_wdata[4]; m_rearm = cfg_wdata[3]; m_esel = cfg_wdata[2:1];
    end
    m_sync = {m_sync[1:0], edge_in};
    m_st = nxt;
    @(negedge clk);
    chk({tag, " val"},   val_o,   m_val);
    chk({tag, " out"},   W'(out_o),   W'(m_out));
    chk({tag, " event"}, W'(event_o), W'(m_evt));
    chk({tag, " armed"}, W'(armed_o), W'(m_st != 0));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 armed", W'(armed_o), '0);
    chk("R1 event", W'(event_o), '0);
    chk("R1 out", W'(out_o), '0);
    chk("R1 val", val_o, '0);

    // R2 compare on fine view
    tag = "R2";
    cfg_we = 1; cfg_wdata = 5'b00000; step(); clr_strobes();
    tb_fine = 5; tb_coarse = 100;
    val_we = 1; wdata = 9; step(); clr_strobes();
    chk("R11 armed after value write", W'(armed_o), 1);
    tb_fine = 3; step();
    chk("R2 no match", W'(event_o), 0);
    tb_fine = 9; step();
    chk("R2 event", W'(event_o), 1);
    chk("R2 out toggled", W'(out_o), 1);
    chk("R2 disarmed", W'(armed_o), 0);
    step();
    chk("R2 single pulse", W'(event_o), 0);

    // R3 coarse view
    tag = "R3";
    cfg_we = 1; cfg_wdata = 5'b10000; step(); clr_strobes();
    val_we = 1; wdata = 100; tb_fine = 100; tb_coarse = 7; step(); clr_strobes();
    step();
    chk("R3 fine view ignored", W'(event_o), 0);
    tb_coarse = 100; step();
    chk("R3 coarse match", W'(event_o), 1);
    chk("R3 out", W'(out_o), 0);

    // R4/R5 rising capture, no rearm
    tag = "R5";
    cfg_we = 1; cfg_wdata = 5'b00101; step(); clr_strobes();
    chk("R4 capture armed", W'(armed_o), 1);
    edge_in = 1; tb_fine = 42; steps(2);
    chk("R5 not yet", W'(event_o), 0);
    step();
    chk("R5 capture event", W'(event_o), 1);
    chk("R5 captured value", val_o, 42);
    chk("R6 one-shot disarm", W'(armed_o), 0);

    // falling, rearm
    cfg_we = 1; cfg_wdata = 5'b01011; step(); clr_strobes();
    edge_in = 0; tb_fine = 50; steps(3);
    chk("R5 falling event", W'(event_o), 1);
    chk("R5 falling value", val_o, 50);
    chk("R6 rearm stays armed", W'(armed_o), 1);
    edge_in = 1; tb_fine = 60;
    for (int i = 0; i < 4; i++) begin step(); chk("R5 rising ignored", W'(event_o), 0); end
    chk("R5 value kept", val_o, 50);

    // edge code none
    cfg_we = 1; cfg_wdata = 5'b00001; step(); clr_strobes();
    edge_in = 0; steps(4); edge_in = 1;
    for (int i = 0; i < 4; i++) begin step(); chk("R5 none code", W'(event_o), 0); end
    chk("R5 none still armed", W'(armed_o), 1);

    // code 11 behaves as rising
    cfg_we = 1; cfg_wdata = 5'b00111; step(); clr_strobes();
    edge_in = 0;
    for (int i = 0; i < 4; i++) begin step(); chk("R5 code11 fall ignored", W'(event_o), 0); end
    edge_in = 1; tb_fine = 77; steps(3);
    chk("R5 code11 rise", W'(event_o), 1);
    chk("R5 code11 value", val_o, 77);

    // R7 arm-set on capture-armed channel
    tag = "R7";
    cfg_we = 1; cfg_wdata = 5'b01101; step(); clr_strobes();
    arm_set = 1; step(); clr_strobes();
    chk("R7 still armed", W'(armed_o), 1);
    edge_in = 0;
    for (int i = 0; i < 4; i++) begin step(); chk("R7 no compare fire", W'(event_o), 0); end
    edge_in = 1; tb_fine = 88; steps(3);
    chk("R7 still capturing", W'(event_o), 1);
    chk("R7 captured", val_o, 88);
    tag = "R8";
    arm_clr = 1; step(); clr_strobes();
    chk("R8 clear disarms", W'(armed_o), 0);
    chk("R8 clear no event", W'(event_o), 0);
    tag = "R7";
    arm_set = 1; step(); clr_strobes();
    chk("R7 idle arm-set arms compare", W'(armed_o), 1);
    step();
    chk("R7 compare with old value", W'(event_o), 1);
    chk("R7 out", W'(out_o), 1);

    // R8 clear with same-cycle match
    tag = "R8";
    val_we = 1; wdata = 88; tb_fine = 0; step(); clr_strobes();
    tb_fine = 88; arm_clr = 1; step(); clr_strobes();
    chk("R8 event kept", W'(event_o), 1);
    chk("R8 disarmed", W'(armed_o), 0);
    chk("R8 out", W'(out_o), 0);

    // R9 alias write
    tag = "R9";
    alias_we = 1; wdata = 123; step(); clr_strobes();
    chk("R9 alias value", val_o, 123);
    chk("R9 alias no arm", W'(armed_o), 0);
    tb_fine = 123; step();
    chk("R9 no compare", W'(event_o), 0);
    cfg_we = 1; cfg_wdata = 5'b01101; step(); clr_strobes();
    alias_we = 1; wdata = 5; step(); clr_strobes();
    chk("R9 capture kept", W'(armed_o), 1);
    chk("R9 value", val_o, 5);
    edge_in = 0; steps(4); edge_in = 1; tb_fine = 11; steps(3);
    chk("R9 capture still works", val_o, 11);

    // R10 priorities
    tag = "R10";
    arm_clr = 1; val_we = 1; wdata = 300; step(); clr_strobes();
    chk("R10 clear beats value write", W'(armed_o), 0);
    chk("R10 value still written", val_o, 300);
    arm_clr = 1; arm_set = 1; step(); clr_strobes();
    chk("R10 clear beats set", W'(armed_o), 0);
    cfg_we = 1; cfg_wdata = 5'b01101; step(); clr_strobes();
    edge_in = 0; steps(4); edge_in = 1; tb_fine = 20; steps(2);
    alias_we = 1; wdata = 200; step(); clr_strobes();
    chk("R10 capture event", W'(event_o), 1);
    chk("R10 write beats capture", val_o, 200);
    cfg_we = 1; cfg_wdata = 5'b00101; arm_clr = 1; step(); clr_strobes();
    chk("R10 clear beats cfg", W'(armed_o), 0);

    // random mix
    tag = "RAND";
    for (int c = 0; c < 4000; c++) begin
      cfg_we    = ($urandom_range(0, 15) == 0);
      cfg_wdata = 5'($urandom);
      val_we    = ($urandom_range(0, 9) == 0);
      alias_we  = ($urandom_range(0, 11) == 0);
      arm_set   = ($urandom_range(0, 9) == 0);
      arm_clr   = ($urandom_range(0, 13) == 0);
      wdata     = W'($urandom_range(0, 7));
      tb_fine   = W'($urandom_range(0, 7));
      tb_coarse = W'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) edge_in = ~edge_in;
      step();
    end
    clr_strobes();
    summary();
  end
endmodule